// File: doc/BRIEF.md
# Modulo 2^n − 2^k − 1 Adder

This block adds two residues modulo M = 2^N − 2^K − 1 and returns a result that is again in the range [0, M−1]. It is meant to sit inside one arithmetic channel of a residue datapath. Both operands must already be reduced below M. A result always falls into one of two cases. If A + B is below M, the result is A + B unchanged. Otherwise the result is the low N bits of A + B + T, where T = 2^K + 1 = 2^N − M.

The design makes one pass through four stages, with no second adder and no second cycle. The pre-processing stage forms bitwise generate and propagate terms. A parallel-prefix network turns them into group terms. The carry-modification stage corrects the carries twice: first for the "+1" part of T, which enters at bit 0, and then for the "+2^K" part, which enters at bit K. The same stage decides whether the corrected sum overflows N bits. The sum stage then picks the corrected sum or the plain sum. A parameter selects the prefix topology. Another parameter adds one output register stage, with a valid flag alongside the result.

Legal parameters satisfy 1 ≤ K ≤ N−2. Operands at or above M are outside the contract.

Top module: `mod_adder_2n2k1`

## Requirements
- R1: For every pair of operands below M, `sum` equals (A + B) mod M. This includes A = B = M−1, which gives M−2, and A + B = M exactly, which gives 0.
- R2: For operands below M, `sum` is always strictly less than M.
- R3: When A + B < M, `sum` equals A + B, with no correction applied.
- R4: When A + B ≥ M, `sum` equals A + B − M, which is the low N bits of A + B + 2^K + 1.
- R5: With OUT_REG = 1, the result and `out_valid` appear one clock after the operands, and `out_valid` equals `in_valid` delayed by one clock.
- R6: With OUT_REG = 1, a clock edge with `in_valid` low leaves `sum` unchanged, whatever `a` and `b` carry at that edge.
- R7: While `rst_n` is low (active low), and afterwards until the first valid input, `out_valid` is 0 and `sum` is 0 (OUT_REG = 1).
- R8: With OUT_REG = 0, `sum` is a combinational function of `a` and `b` in the same cycle, and `out_valid` equals `in_valid`.
- R9: TOPO = 0 (Kogge-Stone) and TOPO = 1 (Sklansky) give identical results for every legal operand pair.
- R10: B = 0 gives `sum` = A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, used only when OUT_REG = 1 |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| in_valid | input | 1 | Qualifies `a` and `b` |
| a | input | N | First operand, below M |
| b | input | N | Second operand, below M |
| out_valid | output | 1 | Qualifies `sum` |
| sum | output | N | (a + b) mod M |

## Verification
The bench builds three instances, and each one is swept over every legal operand pair.

| Instance | N | K | M | Prefix | Output |
|----------|---|---|---|--------|--------|
| 1 | 5 | 2 | 27 | Kogge-Stone | registered |
| 2 | 4 | 1 | 13 | Kogge-Stone | combinational |
| 3 | 6 | 4 | 47 | Sklansky | registered |

With moduli this small, every wrap boundary is reached: the sum equal to M, the largest operand pair, and zero operands. Both correction positions are reached too, at K = 1, where the "+2^K" injection sits next to the "+1", and at K = N−2, where it sits just below the top bit. Both prefix topologies, and both output variants, are compared against a remainder computed in the bench.

// File: rtl/madd_pkg.sv
package madd_pkg;

    // Selects the carry-prefix network topology.
    typedef enum logic {
        PFX_KOGGE_STONE = 1'b0,
        PFX_SKLANSKY    = 1'b1
    } prefix_kind_e;

endpackage

// File: rtl/madd_pre.sv
// Pre-processing: bitwise generate / propagate of the two operands.
module madd_pre #(
    parameter int N = 8
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic [N-1:0] gen,
    output logic [N-1:0] prop
);
    assign gen  = a & b;
    assign prop = a ^ b;
endmodule

// File: rtl/madd_prefix.sv
// Parallel-prefix network: g_grp[i] = G[i:0], p_grp[i] = P[i:0].
module madd_prefix
    import madd_pkg::*;
#(
    parameter int           W    = 8,
    parameter prefix_kind_e TOPO = PFX_KOGGE_STONE
) (
    input  logic [W-1:0] g_in,
    input  logic [W-1:0] p_in,
    output logic [W-1:0] g_grp,
    output logic [W-1:0] p_grp
);
    localparam int LVLS = (W > 1) ? $clog2(W) : 0;

    generate
        if (LVLS == 0) begin : g_flat
            assign g_grp = g_in;
            assign p_grp = p_in;
        end else begin : g_tree
            for (genvar l = 0; l < LVLS; l++) begin : lvl
                logic [W-1:0] gi;
                logic [W-1:0] pi;
                logic [W-1:0] go;
                logic [W-1:0] po;
                if (l == 0) begin : g_src_in
                    assign gi = g_in;
                    assign pi = p_in;
                end else begin : g_src_prev
                    assign gi = lvl[l-1].go;
                    assign pi = lvl[l-1].po;
                end
                for (genvar i = 0; i < W; i++) begin : col
                    // Index of the lower group merged into column i at this level.
                    localparam int SRC = (TOPO == PFX_KOGGE_STONE)
                        ? i - (1 << l)
                        : ((((i >> l) & 1) == 1) ? ((i >> l) << l) - 1 : -1);
                    if (SRC >= 0) begin : g_op
                        assign go[i] = gi[i] | (pi[i] & gi[SRC]);
                        assign po[i] = pi[i] & pi[SRC];
                    end else begin : g_pass
                        assign go[i] = gi[i];
                        assign po[i] = pi[i];
                    end
                end
            end
            assign g_grp = lvl[LVLS-1].go;
            assign p_grp = lvl[LVLS-1].po;
        end
    endgenerate
endmodule

// File: rtl/madd_cmod.sv
// Carry modification. The prefix terms of A+B yield:
//   - plain carries of A+B;
//   - first correction: carries of A+B+1 (carry-in at bit 0);
//   - second correction: carries of injecting 2^K into that sum (AND-prefix chain).
// Overflow of A+B+T past N bits selects the corrected sum.
module madd_cmod
    import madd_pkg::*;
#(
    parameter int           N    = 8,
    parameter int           K    = 3,
    parameter prefix_kind_e TOPO = PFX_KOGGE_STONE
) (
    input  logic [N-1:0] prop,
    input  logic [N-1:0] g_grp,
    input  logic [N-1:0] p_grp,
    output logic [N-1:0] c_plain,
    output logic [N-1:0] y_inc,
    output logic [N-1:0] c_inj,
    output logic         ovf
);
    localparam int HW = N - K;

    logic [N-1:0]  c_one;
    logic          y_top;
    logic [HW-1:0] chain_g_unused;
    logic [HW-1:0] chain_and;

    always_comb begin
        c_one      = '0;
        c_plain    = '0;
        c_one[0]   = 1'b1;
        for (int j = 1; j < N; j++) begin
            c_plain[j] = g_grp[j-1];
            c_one[j]   = g_grp[j-1] | p_grp[j-1];
        end
        y_inc = prop ^ c_one;
        y_top = g_grp[N-1] | p_grp[N-1];
    end

    // AND-prefix over y_inc[N-1:K]: chain_and[i] = &y_inc[K+i:K].
    madd_prefix #(
        .W    (HW),
        .TOPO (TOPO)
    ) chain_i (
        .g_in  ('0),
        .p_in  (y_inc[N-1:K]),
        .g_grp (chain_g_unused),
        .p_grp (chain_and)
    );

    always_comb begin
        c_inj    = '0;
        c_inj[K] = 1'b1;
        for (int i = 0; i < HW - 1; i++) begin
            c_inj[K+1+i] = chain_and[i];
        end
        ovf = y_top | chain_and[HW-1];
    end
endmodule

// File: rtl/madd_sum.sv
// Sum stage: corrected sum on overflow, otherwise plain A+B.
module madd_sum #(
    parameter int N = 8
) (
    input  logic [N-1:0] prop,
    input  logic [N-1:0] c_plain,
    input  logic [N-1:0] y_inc,
    input  logic [N-1:0] c_inj,
    input  logic         ovf,
    output logic [N-1:0] res
);
    assign res = ovf ? (y_inc ^ c_inj) : (prop ^ c_plain);
endmodule

// File: rtl/mod_adder_2n2k1.sv
// (a + b) mod (2^N - 2^K - 1), single pass, optional output register.
module mod_adder_2n2k1
    import madd_pkg::*;
#(
    parameter int           N       = 8,
    parameter int           K       = 3,
    parameter bit           OUT_REG = 1'b1,
    parameter prefix_kind_e TOPO    = PFX_KOGGE_STONE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    output logic         out_valid,
    output logic [N-1:0] sum
);
    logic [N-1:0] gen;
    logic [N-1:0] prop;
    logic [N-1:0] g_grp;
    logic [N-1:0] p_grp;
    logic [N-1:0] c_plain;
    logic [N-1:0] y_inc;
    logic [N-1:0] c_inj;
    logic         ovf;
    logic [N-1:0] res;

    madd_pre #(.N(N)) pre_i (
        .a    (a),
        .b    (b),
        .gen  (gen),
        .prop (prop)
    );

    madd_prefix #(.W(N), .TOPO(TOPO)) prefix_i (
        .g_in  (gen),
        .p_in  (prop),
        .g_grp (g_grp),
        .p_grp (p_grp)
    );

    madd_cmod #(.N(N), .K(K), .TOPO(TOPO)) cmod_i (
        .prop    (prop),
        .g_grp   (g_grp),
        .p_grp   (p_grp),
        .c_plain (c_plain),
        .y_inc   (y_inc),
        .c_inj   (c_inj),
        .ovf     (ovf)
    );

    madd_sum #(.N(N)) sum_i (
        .prop    (prop),
        .c_plain (c_plain),
        .y_inc   (y_inc),
        .c_inj   (c_inj),
        .ovf     (ovf),
        .res     (res)
    );

    generate
        if (OUT_REG) begin : g_reg
            typedef struct packed {
                logic         vld;
                logic [N-1:0] val;
            } ostate_t;

            ostate_t st_d;
            ostate_t st_q;

            always_comb begin
                st_d     = st_q;
                st_d.vld = in_valid;
                if (in_valid) begin
                    st_d.val = res;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            assign out_valid = st_q.vld;
            assign sum       = st_q.val;
        end else begin : g_comb
            logic clk_unused;
            logic rst_unused;
            assign clk_unused = clk;
            assign rst_unused = rst_n;
            assign out_valid  = in_valid;
            assign sum        = res;
        end
    endgenerate
endmodule

// File: rtl/madd_chk.sv
// Property checker bound to every mod_adder_2n2k1 instance.
module madd_chk #(
    parameter int N       = 8,
    parameter int K       = 3,
    parameter bit OUT_REG = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [N-1:0] a,
    input logic [N-1:0] b,
    input logic         out_valid,
    input logic [N-1:0] sum
);
    localparam logic [N:0] MODV = (N+1)'((1 << N) - (1 << K) - 1);

    logic [N:0]   raw_w;
    logic [N-1:0] ref_w;
    logic         legal_w;
    logic         seen_q;

    assign raw_w   = {1'b0, a} + {1'b0, b};
    assign ref_w   = (raw_w >= MODV) ? N'(raw_w - MODV) : N'(raw_w);
    assign legal_w = ({1'b0, a} < MODV) && ({1'b0, b} < MODV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    generate
        if (OUT_REG) begin : g_reg_props
            a_r1_matches_reference: assert property (@(posedge clk) disable iff (!rst_n)
                seen_q && $past(in_valid && legal_w) |-> sum == $past(ref_w));
            a_r2_below_modulus: assert property (@(posedge clk) disable iff (!rst_n)
                seen_q && $past(in_valid && legal_w) |-> {1'b0, sum} < MODV);
            a_r5_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
                seen_q |-> out_valid == $past(in_valid));
            a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
                seen_q && !$past(in_valid) |-> $stable(sum));
            a_r7_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (!out_valid && sum == '0));
            a_r10_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
                seen_q && $past(in_valid && legal_w && b == '0) |-> sum == $past(a));
        end else begin : g_comb_props
            a_r8_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && legal_w |-> sum == ref_w);
            a_r8_valid_passthru: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == in_valid);
            a_r2_below_modulus_comb: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid && legal_w |-> {1'b0, sum} < MODV);
        end
    endgenerate
endmodule

bind mod_adder_2n2k1 madd_chk #(
    .N       (N),
    .K       (K),
    .OUT_REG (OUT_REG)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a         (a),
    .b         (b),
    .out_valid (out_valid),
    .sum       (sum)
);

// File: tb/mod_adder_2n2k1_tb_top.sv
module mod_adder_2n2k1_tb_top;
    import madd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    // Instance 1: N=5, K=2, registered, Kogge-Stone -> M=27
    localparam int M1 = 27;
    // Instance 2: N=4, K=1, combinational -> M=13
    localparam int M2 = 13;
    // Instance 3: N=6, K=4, registered, Sklansky -> M=47
    localparam int M3 = 47;

    logic clk = 1'b0;
    logic rst_n = 1'b0;

    logic       v1 = 1'b0;
    logic [4:0] a1 = '0;
    logic [4:0] b1 = '0;
    logic       ov1;
    logic [4:0] s1;

    logic       v2 = 1'b0;
    logic [3:0] a2 = '0;
    logic [3:0] b2 = '0;
    logic       ov2;
    logic [3:0] s2;

    logic       v3 = 1'b0;
    logic [5:0] a3 = '0;
    logic [5:0] b3 = '0;
    logic       ov3;
    logic [5:0] s3;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mod_adder_2n2k1 #(.N(5), .K(2), .OUT_REG(1'b1), .TOPO(PFX_KOGGE_STONE)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .a(a1), .b(b1),
        .out_valid(ov1), .sum(s1)
    );

    mod_adder_2n2k1 #(.N(4), .K(1), .OUT_REG(1'b0), .TOPO(PFX_KOGGE_STONE)) dut_comb_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v2), .a(a2), .b(b2),
        .out_valid(ov2), .sum(s2)
    );

    mod_adder_2n2k1 #(.N(6), .K(4), .OUT_REG(1'b1), .TOPO(PFX_SKLANSKY)) dut_sk_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v3), .a(a3), .b(b3),
        .out_valid(ov3), .sum(s3)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic string case_tag(input int x, input int y, input int m);
        return (x + y < m) ? "R3" : "R4";
    endfunction

    // Registered instance 1: drive at a falling edge, result visible at the next one.
    task automatic apply1(input int x, input int y, input string req);
        @(negedge clk);
        v1 = 1'b1; a1 = 5'(x); b1 = 5'(y);
        @(negedge clk);
        check(int'(s1) == (x + y) % M1, req, int'(s1), (x + y) % M1);
    endtask

    task automatic apply3(input int x, input int y);
        @(negedge clk);
        v3 = 1'b1; a3 = 6'(x); b3 = 6'(y);
        @(negedge clk);
        check(int'(s3) == (x + y) % M3, "R9", int'(s3), (x + y) % M3);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int held;
        // R7: outputs cleared while in reset
        repeat (3) @(negedge clk);
        check(ov1 == 1'b0, "R7", int'(ov1), 0);
        check(s1 == '0, "R7", int'(s1), 0);
        check(s3 == '0, "R7", int'(s3), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(ov1 == 1'b0 && s1 == '0, "R7", int'(s1), 0);

        // R5: valid appears one cycle after the operands
        @(negedge clk);
        v1 = 1'b1; a1 = 5'd3; b1 = 5'd4;
        #1;
        check(ov1 == 1'b0, "R5", int'(ov1), 0);
        @(negedge clk);
        check(ov1 == 1'b1, "R5", int'(ov1), 1);
        check(int'(s1) == 7, "R5", int'(s1), 7);

        // R6: idle cycle with new operands leaves sum unchanged
        v1 = 1'b0; a1 = 5'd20; b1 = 5'd20;
        held = int'(s1);
        @(negedge clk);
        check(ov1 == 1'b0, "R5", int'(ov1), 0);
        check(int'(s1) == held, "R6", int'(s1), held);
        @(negedge clk);
        check(int'(s1) == held, "R6", int'(s1), held);

        // R1 / R10 directed corners
        apply1(M1 - 1, M1 - 1, "R1");
        apply1(13, 14, "R1");
        apply1(0, 0, "R10");
        apply1(M1 - 1, 0, "R10");
        apply1(9, 0, "R10");

        // Exhaustive sweep, instance 1 (R3 / R4 by region, R2 bound)
        for (int x = 0; x < M1; x++) begin
            for (int y = 0; y < M1; y++) begin
                apply1(x, y, case_tag(x, y, M1));
                check(int'(s1) < M1, "R2", int'(s1), M1 - 1);
            end
        end
        v1 = 1'b0;

        // R8: combinational instance, same-cycle result and valid
        for (int x = 0; x < M2; x++) begin
            for (int y = 0; y < M2; y++) begin
                @(negedge clk);
                v2 = ((x + y) % 2) == 0; a2 = 4'(x); b2 = 4'(y);
                #1;
                check(int'(s2) == (x + y) % M2, "R8", int'(s2), (x + y) % M2);
                check(ov2 == v2, "R8", int'(ov2), int'(v2));
            end
        end
        v2 = 1'b0;

        // R9: Sklansky instance, all pairs
        for (int x = 0; x < M3; x++) begin
            for (int y = 0; y < M3; y++) begin
                apply3(x, y);
            end
        end
        v3 = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule